// File: doc/BRIEF.md
# Five-Channel Compare Timer

A word-addressed timer unit built around a free-running 32-bit time base and five compare channels. Each channel holds a compare value and a don't-care mask over the top five bits of the time base. A channel matches when every unmasked bit agrees. A match can drive an output pin to a programmed level, and it can set a sticky status bit. The status bit can raise the channel's interrupt line.

Software loads the time base and programs the channel registers over a simple single-cycle request bus. Status bits can also be set or cleared from software through two separate addresses. Each interrupt line is the AND of its status bit and its mask bit.

Top module: `cmp_timer_unit`

## Requirements
- R1: After reset every register, including the time base, reads zero. Every pin, every interrupt line and the read data are 0.
- R2: A write to offset 0x00 loads the time base at that edge. In every other cycle the time base increments by one and wraps from 0xFFFFFFFF to 0. A read of 0x00 returns the value held before the read edge.
- R3: Output enable sits at 0x10 and output level at 0x14. Channel n occupies bit 31-n. Only bits 31:27 are stored, and the other bits read zero.
- R4: The compare value for channel n sits at 0x80+4n and its mask at 0xC0+4n. Each keeps only bits 31:27. A channel matches when time base bits 31:27 equal the compare bits at every position whose mask bit is 0.
- R5: pin_o[n] is 0 while the channel's enable bit is clear. While it is set, pin_o[n] equals the level bit on a match and the inverse of the level bit otherwise.
- R6: The interrupt mask (0x18), status and interrupt enable (0x24) registers keep bits 15:11, with channel n at bit 15-n. In each cycle in which channel n matches and its enable bit is set, its status bit is set at the next edge.
- R7: A write to 0x1C ORs the written bits into status, and a write to 0x20 clears them. A read of either address returns status. A status bit clears only by a write to 0x20, and a hardware set in the same cycle overrides that clear.
- R8: irq_o[n] is 1 exactly when status bit 15-n and mask bit 15-n are both 1.
- R9: A read of an unmapped or non-word-aligned offset returns 0xFFFFFFFF. Writes to such offsets change nothing.
- R10: An access with be_i other than 4'hF is not a 32-bit access. It writes nothing, and as a read it returns 0xFFFFFFFF.
- R11: Read data appears on rdata_o after the edge that samples the read request. It holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| be_i | input | 4 | Byte enables; only 4'hF is accepted |
| addr_i | input | 8 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| pin_o | output | 5 | Channel output pins, bit n = channel n |
| irq_o | output | 5 | Channel interrupt lines, bit n = channel n |

## Verification
Some rules are checked by assertions on every cycle: the time base steps by one or loads the written value, status bits are sticky and are set by enabled matches, and rejected or misaligned reads return all ones. Other behaviour can only be shown by the bench's scenarios, which run it against a behavioural model. This covers field placement on read-back, masked compare results on the pins, software set and clear of status, interrupt masking, and the time base wrapping.

// File: rtl/ctu_pkg.sv
package ctu_pkg;
  localparam int unsigned OFF_TB   = 'h00;
  localparam int unsigned OFF_OE   = 'h10;
  localparam int unsigned OFF_OL   = 'h14;
  localparam int unsigned OFF_IM   = 'h18;
  localparam int unsigned OFF_SSET = 'h1C;
  localparam int unsigned OFF_SCLR = 'h20;
  localparam int unsigned OFF_IE   = 'h24;
  localparam int unsigned OFF_CMP  = 'h80;
  localparam int unsigned OFF_MSK  = 'hC0;
  localparam int unsigned IRQ_MSB  = 15;
endpackage

// File: rtl/ctu_timebase.sv
module ctu_timebase #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] tb_o
);
  logic [W-1:0] tb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tb_q <= '0;
    else if (load_i) tb_q <= load_val_i;
    else             tb_q <= tb_q + W'(1);
  end

  assign tb_o = tb_q;

  // R2
  tb_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> tb_o == ($past(tb_o) + W'(1)));
  // R2
  tb_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> tb_o == $past(load_val_i));
endmodule

// File: rtl/ctu_channel.sv
module ctu_channel #(
  parameter int unsigned CMP_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_we_i,
  input  logic             msk_we_i,
  input  logic [CMP_W-1:0] wfield_i,
  input  logic [CMP_W-1:0] tb_field_i,
  input  logic             oe_i,
  input  logic             lvl_i,
  output logic [CMP_W-1:0] cmp_o,
  output logic [CMP_W-1:0] msk_o,
  output logic             match_o,
  output logic             pin_o
);
  logic [CMP_W-1:0] cmp_q, msk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '0;
      msk_q <= '0;
    end else begin
      if (cmp_we_i) cmp_q <= wfield_i;
      if (msk_we_i) msk_q <= wfield_i;
    end
  end

  // masked bits are don't-care
  assign match_o = ((tb_field_i ^ cmp_q) & ~msk_q) == '0;
  assign pin_o   = oe_i & (match_o ? lvl_i : ~lvl_i);
  assign cmp_o   = cmp_q;
  assign msk_o   = msk_q;
endmodule

// File: rtl/ctu_status.sv
module ctu_status #(
  parameter int unsigned NCH = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           set_we_i,
  input  logic           clr_we_i,
  input  logic [NCH-1:0] wbits_i,
  input  logic [NCH-1:0] hw_set_i,
  output logic [NCH-1:0] status_o
);
  logic [NCH-1:0] st_q, sw_set, sw_clr;

  assign sw_set = set_we_i ? wbits_i : '0;
  assign sw_clr = clr_we_i ? wbits_i : '0;

  // hardware set overrides a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= (st_q & ~sw_clr) | sw_set | hw_set_i;
  end

  assign status_o = st_q;

  // R7
  st_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_we_i |=> (status_o & $past(status_o)) == $past(status_o));
  // R6
  st_hwset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_set_i != '0) |=> (status_o & $past(hw_set_i)) == $past(hw_set_i));
endmodule

// File: rtl/cmp_timer_unit.sv
module cmp_timer_unit
  import ctu_pkg::*;
#(
  parameter int unsigned NCH    = 5,
  parameter int unsigned CMP_W  = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [DATA_W/8-1:0] be_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [NCH-1:0]      pin_o,
  output logic [NCH-1:0]      irq_o
);
  localparam int unsigned CMP_LSB = DATA_W - CMP_W;

  logic                full, wr, aligned;
  logic [DATA_W-1:0]   tb, rd_val, rdata_q;
  logic [NCH-1:0]      oe_q, ol_q, im_q, ie_q, status, match, wr_out_bits, wr_irq_bits;
  logic [CMP_W-1:0]    cmp_a [NCH];
  logic [CMP_W-1:0]    msk_a [NCH];

  assign full    = req_i && (be_i == '1);
  assign wr      = full && we_i;
  assign aligned = addr_i[1:0] == 2'b00;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned off);
    return a == ADDR_W'(off);
  endfunction

  // channel n sits at MSB-n of its field
  always_comb begin
    for (int n = 0; n < NCH; n++) begin
      wr_out_bits[n] = wdata_i[DATA_W-1-n];
      wr_irq_bits[n] = wdata_i[IRQ_MSB-n];
    end
  end

  ctu_timebase #(.W(DATA_W)) u_tb (
    .clk_i, .rst_ni,
    .load_i     (wr && hit(addr_i, OFF_TB)),
    .load_val_i (wdata_i),
    .tb_o       (tb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q <= '0; ol_q <= '0; im_q <= '0; ie_q <= '0;
    end else if (wr) begin
      if (hit(addr_i, OFF_OE)) oe_q <= wr_out_bits;
      if (hit(addr_i, OFF_OL)) ol_q <= wr_out_bits;
      if (hit(addr_i, OFF_IM)) im_q <= wr_irq_bits;
      if (hit(addr_i, OFF_IE)) ie_q <= wr_irq_bits;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    ctu_channel #(.CMP_W(CMP_W)) u_ch (
      .clk_i, .rst_ni,
      .cmp_we_i   (wr && hit(addr_i, OFF_CMP + 4*g)),
      .msk_we_i   (wr && hit(addr_i, OFF_MSK + 4*g)),
      .wfield_i   (wdata_i[DATA_W-1 -: CMP_W]),
      .tb_field_i (tb[DATA_W-1 -: CMP_W]),
      .oe_i       (oe_q[g]),
      .lvl_i      (ol_q[g]),
      .cmp_o      (cmp_a[g]),
      .msk_o      (msk_a[g]),
      .match_o    (match[g]),
      .pin_o      (pin_o[g])
    );
  end

  ctu_status #(.NCH(NCH)) u_st (
    .clk_i, .rst_ni,
    .set_we_i (wr && hit(addr_i, OFF_SSET)),
    .clr_we_i (wr && hit(addr_i, OFF_SCLR)),
    .wbits_i  (wr_irq_bits),
    .hw_set_i (match & ie_q),
    .status_o (status)
  );

  assign irq_o = status & im_q;

  always_comb begin
    rd_val = '1;
    if (full && aligned) begin
      if (hit(addr_i, OFF_TB)) rd_val = tb;
      if (hit(addr_i, OFF_OE) || hit(addr_i, OFF_OL) || hit(addr_i, OFF_IM) ||
          hit(addr_i, OFF_SSET) || hit(addr_i, OFF_SCLR) || hit(addr_i, OFF_IE))
        rd_val = '0;
      for (int n = 0; n < NCH; n++) begin
        if (hit(addr_i, OFF_OE)) rd_val[DATA_W-1-n] = oe_q[n];
        if (hit(addr_i, OFF_OL)) rd_val[DATA_W-1-n] = ol_q[n];
        if (hit(addr_i, OFF_IM)) rd_val[IRQ_MSB-n]  = im_q[n];
        if (hit(addr_i, OFF_SSET) || hit(addr_i, OFF_SCLR)) rd_val[IRQ_MSB-n] = status[n];
        if (hit(addr_i, OFF_IE)) rd_val[IRQ_MSB-n]  = ie_q[n];
        if (hit(addr_i, OFF_CMP + 4*n)) rd_val = {cmp_a[n], {CMP_LSB{1'b0}}};
        if (hit(addr_i, OFF_MSK + 4*n)) rd_val = {msk_a[n], {CMP_LSB{1'b0}}};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rdata_q <= '0;
    else if (req_i && !we_i) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;

  // R10
  partial_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && be_i != '1) |=> rdata_o == '1);
  // R9
  misalign_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i[1:0] != 2'b00) |=> rdata_o == '1);
endmodule

// File: tb/cmp_timer_unit_tb_top.sv
module cmp_timer_unit_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        req = 0, we = 0;
  logic [3:0]  be = 4'hF;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [4:0]  pin, irq;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cmp_timer_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .be_i(be),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pin_o(pin), .irq_o(irq)
  );

  // reference model: full 32-bit registers
  bit [31:0] m_tb, m_oe, m_ol, m_im, m_st, m_ie, m_rd;
  bit [31:0] m_cmp [5];
  bit [31:0] m_msk [5];

  function automatic bit m_hit(int n);
    return (((m_tb ^ m_cmp[n]) & ~m_msk[n]) & 32'hF800_0000) == 0;
  endfunction

  function automatic bit [31:0] m_read(bit [7:0] a, bit [3:0] b);
    if (b != 4'hF || a[1:0] != 0) return 32'hFFFF_FFFF;
    case (a)
      8'h00: return m_tb;
      8'h10: return m_oe;
      8'h14: return m_ol;
      8'h18: return m_im;
      8'h1C, 8'h20: return m_st;
      8'h24: return m_ie;
      default: ;
    endcase
    if (a >= 8'h80 && a < 8'h94) return m_cmp[(a - 8'h80) / 4];
    if (a >= 8'hC0 && a < 8'hD4) return m_msk[(a - 8'hC0) / 4];
    return 32'hFFFF_FFFF;
  endfunction

  function automatic bit [4:0] exp_pin();
    bit [4:0] p = 0;
    for (int n = 0; n < 5; n++)
      if (m_oe[31-n]) p[n] = m_hit(n) ? m_ol[31-n] : !m_ol[31-n];
    return p;
  endfunction

  function automatic bit [4:0] exp_irq();
    bit [4:0] q = 0;
    for (int n = 0; n < 5; n++) q[n] = m_st[15-n] & m_im[15-n];
    return q;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tb <= 0; m_oe <= 0; m_ol <= 0; m_im <= 0; m_st <= 0; m_ie <= 0; m_rd <= 0;
      for (int n = 0; n < 5; n++) begin m_cmp[n] <= 0; m_msk[n] <= 0; end
    end else begin : upd
      bit [31:0] ns;
      bit wok;
      ns  = m_st;
      wok = req && we && be == 4'hF;
      if (req && !we) m_rd <= m_read(addr, be);
      m_tb <= (wok && addr == 8'h00) ? wdata : m_tb + 1;
      if (wok) begin
        case (addr)
          8'h10: m_oe <= wdata & 32'hF800_0000;
          8'h14: m_ol <= wdata & 32'hF800_0000;
          8'h18: m_im <= wdata & 32'h0000_F800;
          8'h1C: ns = ns | (wdata & 32'h0000_F800);
          8'h20: ns = ns & ~(wdata & 32'h0000_F800);
          8'h24: m_ie <= wdata & 32'h0000_F800;
          default: ;
        endcase
        for (int n = 0; n < 5; n++) begin
          if (addr == 8'h80 + 8'(4*n)) m_cmp[n] <= wdata & 32'hF800_0000;
          if (addr == 8'hC0 + 8'(4*n)) m_msk[n] <= wdata & 32'hF800_0000;
        end
      end
      for (int n = 0; n < 5; n++) if (m_hit(n) && m_ie[15-n]) ns[15-n] = 1;
      m_st <= ns;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_cmp += 3;
      if (pin !== exp_pin()) begin n_bad++; $display("FAIL R5 pin act=%b exp=%b", pin, exp_pin()); end
      if (irq !== exp_irq()) begin n_bad++; $display("FAIL R8 irq act=%b exp=%b", irq, exp_irq()); end
      if (rdata !== m_rd) begin n_bad++; $display("FAIL R11 rdata act=%h exp=%h", rdata, m_rd); end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(bit [7:0] a, bit [31:0] d, bit [3:0] b = 4'hF);
    req = 1; we = 1; addr = a; wdata = d; be = b;
    @(posedge clk); #2;
    req = 0; we = 0; be = 4'hF;
  endtask

  task automatic bus_rd(bit [7:0] a, output logic [31:0] v, input bit [3:0] b = 4'hF);
    req = 1; we = 0; addr = a; be = b;
    @(posedge clk); #2;
    req = 0; be = 4'hF;
    v = rdata;
  endtask

  task automatic idle(int c);
    repeat (c) @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1
    chk("R1 pin", {27'd0, pin}, 0);
    chk("R1 irq", {27'd0, irq}, 0);
    chk("R1 rdata", rdata, 0);
    bus_rd(8'h10, v); chk("R1 oe read", v, 0);
    // R3
    bus_wr(8'h10, 32'hFFFF_FFFF);
    bus_rd(8'h10, v); chk("R3 oe field", v, 32'hF800_0000);
    bus_wr(8'h14, 32'hA5A5_A5A5);
    bus_rd(8'h14, v); chk("R3 level field", v, 32'hA000_0000);
    // R5: all channels match
    bus_wr(8'h00, 32'h0000_0100);
    chk("R5 match pins", {27'd0, pin}, 32'h05);
    bus_wr(8'h00, 32'h8000_0000);
    chk("R5 mismatch pins", {27'd0, pin}, 32'h1A);
    // R4
    bus_wr(8'h84, 32'hFFFF_FFFF);
    bus_rd(8'h84, v); chk("R4 compare field", v, 32'hF800_0000);
    bus_wr(8'h84, 32'h8000_0000);
    chk("R4 ch1 match", {27'd0, pin}, 32'h18);
    bus_wr(8'hC8, 32'h8000_0000);
    bus_rd(8'hC8, v); chk("R4 mask field", v, 32'h8000_0000);
    chk("R4 masked match", {27'd0, pin}, 32'h1C);
    // R2
    bus_wr(8'h00, 32'hFFFF_FFFF);
    bus_rd(8'h00, v); chk("R2 load", v, 32'hFFFF_FFFF);
    bus_rd(8'h00, v); chk("R2 wrap", v, 32'h0000_0000);
    bus_wr(8'h00, 32'h1234_5678);
    bus_rd(8'h00, v); chk("R2 load2", v, 32'h1234_5678);
    bus_rd(8'h00, v); chk("R2 step", v, 32'h1234_5679);
    // R6 / R7 / R8
    bus_wr(8'h18, 32'hFFFF_FFFF);
    bus_rd(8'h18, v); chk("R6 mask field", v, 32'h0000_F800);
    bus_wr(8'h1C, 32'h0000_A000);
    chk("R8 irq", {27'd0, irq}, 32'h05);
    bus_rd(8'h20, v); chk("R7 read via clear addr", v, 32'h0000_A000);
    bus_wr(8'h20, 32'h0000_8000);
    bus_rd(8'h1C, v); chk("R7 clear", v, 32'h0000_2000);
    chk("R8 irq after clear", {27'd0, irq}, 32'h04);
    bus_wr(8'h18, 32'h0);
    chk("R8 masked off", {27'd0, irq}, 0);
    bus_rd(8'h1C, v); chk("R8 status kept", v, 32'h0000_2000);
    bus_wr(8'h20, 32'h0000_FFFF);
    // R6 hardware set on ch3
    bus_wr(8'hCC, 32'hFFFF_FFFF);
    bus_wr(8'h24, 32'h0000_1000);
    idle(1);
    bus_rd(8'h1C, v); chk("R6 hw set", v, 32'h0000_1000);
    bus_wr(8'h20, 32'h0000_1000);
    idle(1);
    bus_rd(8'h1C, v); chk("R7 hw set beats clear", v, 32'h0000_1000);
    bus_wr(8'h24, 32'h0);
    bus_wr(8'h20, 32'h0000_FFFF);
    bus_rd(8'h1C, v); chk("R7 cleared", v, 0);
    bus_wr(8'h24, 32'hFFFF_FFFF);
    bus_rd(8'h24, v); chk("R6 enable field", v, 32'h0000_F800);
    bus_wr(8'h24, 32'h0);
    // R9
    bus_rd(8'h08, v); chk("R9 hole", v, 32'hFFFF_FFFF);
    bus_rd(8'h94, v); chk("R9 past compares", v, 32'hFFFF_FFFF);
    bus_rd(8'h86, v); chk("R9 misaligned", v, 32'hFFFF_FFFF);
    bus_wr(8'h0C, 32'h0);
    bus_rd(8'h10, v); chk("R9 write ignored", v, 32'hF800_0000);
    // R10
    bus_wr(8'h10, 32'h0, 4'h3);
    bus_rd(8'h10, v); chk("R10 partial write", v, 32'hF800_0000);
    bus_rd(8'h10, v, 4'h1); chk("R10 partial read", v, 32'hFFFF_FFFF);
    // R11
    bus_rd(8'h14, v);
    idle(3);
    chk("R11 hold", rdata, 32'hA000_0000);
    idle(2);
    finish_run();
  end
endmodule